// File: doc/BRIEF.md
# Dual Counter/Timer with Split Mode

This block holds two counter/timers. Each one has a low byte and a high byte and can run in one of four modes. The modes are a 13-bit prescaler-style counter, a full 16-bit counter, an 8-bit counter that reloads from the high byte, and a fourth mode whose meaning differs between the two timers.

For timer 0, mode 3 splits the timer into two independent 8-bit counters:
- The low byte keeps timer 0's own run, gate and source controls, and it sets flag 0 when it wraps.
- The high byte counts only timer 0's internal time base. It is enabled by timer 1's run bit and it sets flag 1 when it wraps.

While timer 0 is split, timer 1 keeps running in its own mode on its internal time base. Its wraps produce only a one-cycle pulse, which a serial port can use as a baud clock. For timer 1, mode 3 freezes the count, so switching into and out of that mode turns timer 1 off and on.

Counting is paced by a one-cycle clock enable `ce`. Each timer picks either every enabled cycle or every twelfth one. In counter operation a timer instead counts falling edges of its external pin, after a two-flop synchronizer. A byte-wide register port writes and reads the four count bytes, and a separate port writes the two flags.

Top module: `dual_timer`

## Requirements
- R1: After synchronous reset, all four count bytes, both flags and the timer 1 pulse are 0.
- R2: Mode encoding is 0 = 13-bit, 1 = 16-bit, 2 = reload, 3 = split/stop. In mode 1, each count event increments {high,low} as one 16-bit value. A wrap from 0xFFFF to 0x0000 sets the timer's flag, visible in the same cycle as the zero count.
- R3: In mode 0, the count is {high byte, low byte bits 4:0}. Low byte bits 7:5 are held. A wrap of all 13 bits to zero sets the flag.
- R4: In mode 2, the low byte increments. On a wrap it loads the high byte value instead of 0 and sets the flag. The high byte never changes by counting.
- R5: Setting the prescale select bit of a timer to 1 gives it one count per 12 `ce` pulses, phased from reset. Setting it to 0 gives one count per `ce` pulse. No count occurs while `ce` is low.
- R6: With the source select bit at 1, the timer counts synchronized 1-to-0 transitions of its pin, one count per transition, independent of `ce`. It does not count `ce` pulses.
- R7: A timer counts only while its run bit is 1. With its gate bit set, it additionally needs its gate pin high.
- R8: When timer 0 is in mode 3, its low byte is an 8-bit counter. It follows run 0, gate 0 and source 0, and its wrap sets flag 0 without carrying into the high byte.
- R9: When timer 0 is in mode 3, its high byte counts timer 0's internal time base only while run 1 is set. Run 0, gate 0 and the source select have no effect on it. Its wrap from 0xFF sets flag 1.
- R10: While timer 0 is in mode 3, timer 1 in mode 0, 1 or 2 counts its internal time base regardless of run 1, gate 1 and source 1. Its wraps never set flag 1.
- R11: Timer 1 in mode 3 holds both of its bytes.
- R12: Every timer 1 wrap, with or without a split timer 0, drives `t1_ovf_pulse` high for exactly the cycle in which the wrapped count is first visible.
- R13: A flag stays set until a flag write loads 0. If a flag write and a wrap land in the same cycle, the flag ends up set.
- R14: Register select is 0 = timer 0 low, 1 = timer 0 high, 2 = timer 1 low, 3 = timer 1 high. A write loads the selected byte, and `rd_data` returns the selected byte at once. In a cycle where a timer is written, neither of that timer's bytes counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | One-cycle count enable (time base) |
| div12_sel | input | 2 | Per timer: 1 = divide `ce` by 12 |
| t0_mode | input | 2 | Timer 0 mode |
| t1_mode | input | 2 | Timer 1 mode |
| gate_en | input | 2 | Per timer gate enable |
| ext_sel | input | 2 | Per timer: 1 = count external pin |
| run | input | 2 | Per timer run bit |
| cnt_pin | input | 2 | Asynchronous external count pins |
| gate_pin | input | 2 | Gate pins, counting allowed while high |
| wr_en | input | 1 | Count byte write strobe |
| wr_sel | input | 2 | Byte selected for write |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Byte selected for read |
| rd_data | output | 8 | Read data |
| flag_wr | input | 2 | Per flag write strobe |
| flag_wdata | input | 2 | Per flag write value |
| tf0 | output | 1 | Timer 0 wrap flag |
| tf1 | output | 1 | Timer 1 wrap flag |
| t1_ovf_pulse | output | 1 | One-cycle timer 1 wrap pulse |

## Verification
The bench builds the block with its defaults: an 8-bit byte, a divide ratio of 12 and two synchronizer stages. With those values, the divide-by-12 boundary (no count after 11 pulses, one after 12, two after 24) falls within a few dozen cycles of reset. A pin edge takes three clocks to reach the count, so edge counting fits in short waits. Byte-level wraps are reached by preloading counts at 0xFE or 0xFF, which covers the carry, reload and split paths in a handful of `ce` pulses.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

    parameter int DT_W     = 8;
    parameter int DT_M0_LO = 5;

    typedef enum logic [1:0] {
        DT_M13    = 2'd0,
        DT_M16    = 2'd1,
        DT_MRLD   = 2'd2,
        DT_MSPLIT = 2'd3
    } dt_mode_e;

    typedef enum logic [1:0] {
        SEL_LO0 = 2'd0,
        SEL_HI0 = 2'd1,
        SEL_LO1 = 2'd2,
        SEL_HI1 = 2'd3
    } dt_sel_e;

    typedef struct packed {
        logic [DT_W-1:0] lo;
        logic [DT_W-1:0] hi;
        logic            ovf;
    } dt_cnt_s;

    // Result of one count event on a {hi,lo} pair in the given mode.
    function automatic dt_cnt_s dt_step(dt_mode_e m, logic [DT_W-1:0] lo,
                                        logic [DT_W-1:0] hi);
        dt_cnt_s          r;
        logic [DT_W:0]    lsum;
        logic [DT_W:0]    hsum;
        logic [DT_M0_LO:0] psum;
        r    = '{lo: lo, hi: hi, ovf: 1'b0};
        lsum = {1'b0, lo} + {{DT_W{1'b0}}, 1'b1};
        hsum = {1'b0, hi} + {{DT_W{1'b0}}, 1'b1};
        psum = {1'b0, lo[DT_M0_LO-1:0]} + {{DT_M0_LO{1'b0}}, 1'b1};
        case (m)
            DT_M13: begin
                r.lo = {lo[DT_W-1:DT_M0_LO], psum[DT_M0_LO-1:0]};
                if (psum[DT_M0_LO]) begin
                    r.hi  = hsum[DT_W-1:0];
                    r.ovf = hsum[DT_W];
                end
            end
            DT_M16: begin
                r.lo = lsum[DT_W-1:0];
                if (lsum[DT_W]) begin
                    r.hi  = hsum[DT_W-1:0];
                    r.ovf = hsum[DT_W];
                end
            end
            DT_MRLD: begin
                r.lo  = lsum[DT_W] ? hi : lsum[DT_W-1:0];
                r.ovf = lsum[DT_W];
            end
            default: begin
                r.lo  = lsum[DT_W-1:0];
                r.ovf = lsum[DT_W];
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dtmr_sync_edge.sv
module dtmr_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic fall
);
    logic [STAGES-1:0] sh;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            prev <= 1'b0;
        end else begin
            sh   <= {sh[STAGES-2:0], pin};
            prev <= sh[STAGES-1];
        end
    end

    assign fall = prev & ~sh[STAGES-1];

    // R6: a detected transition yields a single count event
    p_single_fall_r6: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall);

endmodule

// File: rtl/dtmr_prescale.sv
module dtmr_prescale #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic ce,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (ce)
            cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
    end

    assign tick = ce && (cnt == LAST);

    // R5: the divider advances only on enabled cycles
    p_div_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !ce |=> cnt == $past(cnt));

endmodule

// File: rtl/dtmr_unit.sv
module dtmr_unit
    import dtmr_pkg::*;
#(
    parameter bit SPLIT_OK = 1'b0
) (
    input  logic            clk,
    input  logic            rst,
    input  dt_mode_e        mode,
    input  logic            inc_lo,
    input  logic            inc_hi,
    input  logic            wr_lo,
    input  logic            wr_hi,
    input  logic [DT_W-1:0] wr_data,
    output logic [DT_W-1:0] lo,
    output logic [DT_W-1:0] hi,
    output logic            ovf_lo,
    output logic            ovf_hi
);
    dt_cnt_s         step;
    logic [DT_W-1:0] lo_n;
    logic [DT_W-1:0] hi_n;
    logic [DT_W:0]   hsum;
    logic            split;
    logic            frozen;

    assign split  = SPLIT_OK && (mode == DT_MSPLIT);
    assign frozen = !SPLIT_OK && (mode == DT_MSPLIT);
    assign hsum   = {1'b0, hi} + {{DT_W{1'b0}}, 1'b1};

    always_comb begin
        step   = dt_step(mode, lo, hi);
        lo_n   = lo;
        hi_n   = hi;
        ovf_lo = 1'b0;
        ovf_hi = 1'b0;
        if (inc_lo && !frozen) begin
            lo_n   = step.lo;
            ovf_lo = step.ovf;
            if (!split)
                hi_n = step.hi;
        end
        if (inc_hi && split) begin
            hi_n   = hsum[DT_W-1:0];
            ovf_hi = hsum[DT_W];
        end
        if (wr_lo) lo_n = wr_data;
        if (wr_hi) hi_n = wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo <= '0;
            hi <= '0;
        end else begin
            lo <= lo_n;
            hi <= hi_n;
        end
    end

    // R4: reload mode never moves the high byte by counting
    p_reload_hi_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == DT_MRLD && !wr_hi) |=> hi == $past(hi));

    // R11: a timer without split capability is frozen in mode 3
    p_stop_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!SPLIT_OK && mode == DT_MSPLIT && !wr_lo && !wr_hi)
        |=> (lo == $past(lo)) && (hi == $past(hi)));

    // R8: in split mode the low byte never carries into the high byte
    p_split_no_carry_r8: assert property (@(posedge clk) disable iff (rst)
        (split && !inc_hi && !wr_hi) |=> hi == $past(hi));

endmodule

// File: rtl/dual_timer.sv
module dual_timer
    import dtmr_pkg::*;
#(
    parameter int PRESCALE    = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ce,
    input  logic [1:0]      div12_sel,
    input  logic [1:0]      t0_mode,
    input  logic [1:0]      t1_mode,
    input  logic [1:0]      gate_en,
    input  logic [1:0]      ext_sel,
    input  logic [1:0]      run,
    input  logic [1:0]      cnt_pin,
    input  logic [1:0]      gate_pin,
    input  logic            wr_en,
    input  logic [1:0]      wr_sel,
    input  logic [DT_W-1:0] wr_data,
    input  logic [1:0]      rd_sel,
    output logic [DT_W-1:0] rd_data,
    input  logic [1:0]      flag_wr,
    input  logic [1:0]      flag_wdata,
    output logic            tf0,
    output logic            tf1,
    output logic            t1_ovf_pulse
);
    localparam int NT = 2;

    dt_mode_e        mode_a [NT];
    logic [NT-1:0]   fall, base_tick, allow, src;
    logic [NT-1:0]   inc_lo, inc_hi, wr_lo, wr_hi, blk;
    logic [NT-1:0]   ovf_lo, ovf_hi;
    logic [DT_W-1:0] lo_q [NT];
    logic [DT_W-1:0] hi_q [NT];
    logic            div_tick;
    logic            t0_split;
    logic            set0, set1;

    assign mode_a[0] = dt_mode_e'(t0_mode);
    assign mode_a[1] = dt_mode_e'(t1_mode);
    assign t0_split  = (mode_a[0] == DT_MSPLIT);

    dtmr_prescale #(.DIV(PRESCALE)) u_pre (
        .clk (clk),
        .rst (rst),
        .ce  (ce),
        .tick(div_tick)
    );

    for (genvar i = 0; i < NT; i++) begin : g_tmr
        dtmr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .pin (cnt_pin[i]),
            .fall(fall[i])
        );

        assign base_tick[i] = div12_sel[i] ? div_tick : ce;
        assign allow[i]     = run[i] && (!gate_en[i] || gate_pin[i]);
        assign src[i]       = ext_sel[i] ? fall[i] : base_tick[i];
        assign wr_lo[i]     = wr_en && (wr_sel == 2'(2 * i));
        assign wr_hi[i]     = wr_en && (wr_sel == 2'(2 * i + 1));
        assign blk[i]       = wr_lo[i] || wr_hi[i];

        dtmr_unit #(.SPLIT_OK(i == 0)) u_unit (
            .clk    (clk),
            .rst    (rst),
            .mode   (mode_a[i]),
            .inc_lo (inc_lo[i]),
            .inc_hi (inc_hi[i]),
            .wr_lo  (wr_lo[i]),
            .wr_hi  (wr_hi[i]),
            .wr_data(wr_data),
            .lo     (lo_q[i]),
            .hi     (hi_q[i]),
            .ovf_lo (ovf_lo[i]),
            .ovf_hi (ovf_hi[i])
        );
    end

    always_comb begin
        inc_lo[0] = allow[0] && src[0] && !blk[0];
        inc_hi[0] = t0_split && run[1] && base_tick[0] && !blk[0];
        inc_hi[1] = 1'b0;
        if (mode_a[1] == DT_MSPLIT)
            inc_lo[1] = 1'b0;
        else if (t0_split)
            inc_lo[1] = base_tick[1] && !blk[1];
        else
            inc_lo[1] = allow[1] && src[1] && !blk[1];
    end

    assign set0 = ovf_lo[0];
    assign set1 = t0_split ? ovf_hi[0] : ovf_lo[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            tf0          <= 1'b0;
            tf1          <= 1'b0;
            t1_ovf_pulse <= 1'b0;
        end else begin
            if (set0)            tf0 <= 1'b1;
            else if (flag_wr[0]) tf0 <= flag_wdata[0];
            if (set1)            tf1 <= 1'b1;
            else if (flag_wr[1]) tf1 <= flag_wdata[1];
            t1_ovf_pulse <= ovf_lo[1];
        end
    end

    always_comb begin
        case (dt_sel_e'(rd_sel))
            SEL_LO0: rd_data = lo_q[0];
            SEL_HI0: rd_data = hi_q[0];
            SEL_LO1: rd_data = lo_q[1];
            default: rd_data = hi_q[1];
        endcase
    end

    // R13: flags are sticky until a flag write
    p_tf0_sticky_r13: assert property (@(posedge clk) disable iff (rst)
        (tf0 && !flag_wr[0]) |=> tf0);
    p_tf1_sticky_r13: assert property (@(posedge clk) disable iff (rst)
        (tf1 && !flag_wr[1]) |=> tf1);

    // R9: with timer 0 split, flag 1 can only rise while run 1 is set
    p_split_tf1_run_r9: assert property (@(posedge clk) disable iff (rst)
        (t0_split && !run[1] && !flag_wr[1] && !tf1) |=> !tf1);

    // R11: timer 1 in mode 3 never pulses
    p_t1_stop_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (mode_a[1] == DT_MSPLIT) |=> !t1_ovf_pulse);

endmodule

// File: tb/dual_timer_tb.sv
module dual_timer_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ce = 1'b0;
    logic [1:0] div12_sel = '0, t0_mode = '0, t1_mode = '0;
    logic [1:0] gate_en = '0, ext_sel = '0, run = '0;
    logic [1:0] cnt_pin = '0, gate_pin = '0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0, rd_sel = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [1:0] flag_wr = '0, flag_wdata = '0;
    logic       tf0, tf1, t1_ovf_pulse;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #10 clk = ~clk;

    dual_timer u_dut (
        .clk(clk), .rst(rst), .ce(ce), .div12_sel(div12_sel),
        .t0_mode(t0_mode), .t1_mode(t1_mode), .gate_en(gate_en),
        .ext_sel(ext_sel), .run(run), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
        .tf0(tf0), .tf1(tf1), .t1_ovf_pulse(t1_ovf_pulse)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
        end
    endtask

    task automatic rd(input string req, input logic [1:0] sel,
                      input logic [7:0] exp);
        rd_sel = sel;
        #1;
        chk(req, $sformatf("byte %0d", sel), rd_data, exp);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_ce(input int n);
        @(negedge clk);
        ce = 1'b1;
        repeat (n) @(negedge clk);
        ce = 1'b0;
    endtask

    task automatic clr_flags();
        @(negedge clk);
        flag_wr = 2'b11; flag_wdata = 2'b00;
        @(negedge clk);
        flag_wr = 2'b00;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ce = 0; div12_sel = 0; t0_mode = 0; t1_mode = 0;
        gate_en = 0; ext_sel = 0; run = 0; cnt_pin = 0; gate_pin = 0;
        wr_en = 0; flag_wr = 0; flag_wdata = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        for (int s = 0; s < 4; s++) rd("R1", 2'(s), 8'h00);
        chk("R1", "tf0", {7'b0, tf0}, 8'h0);
        chk("R1", "tf1", {7'b0, tf1}, 8'h0);
        chk("R1", "pulse", {7'b0, t1_ovf_pulse}, 8'h0);
    endtask

    task automatic t_mode16();
        do_reset();
        t0_mode = 2'd1; run = 2'b01;
        wr(2'd0, 8'hFE); wr(2'd1, 8'hFF);
        pulse_ce(1);
        rd("R2", 2'd0, 8'hFF); rd("R2", 2'd1, 8'hFF);
        chk("R2", "tf0 early", {7'b0, tf0}, 8'h0);
        pulse_ce(1);
        rd("R2", 2'd0, 8'h00); rd("R2", 2'd1, 8'h00);
        chk("R2", "tf0 wrap", {7'b0, tf0}, 8'h1);
        clr_flags();
        chk("R13", "tf0 cleared", {7'b0, tf0}, 8'h0);
    endtask

    task automatic t_mode13();
        do_reset();
        t0_mode = 2'd0; run = 2'b01;
        wr(2'd0, 8'hFE); wr(2'd1, 8'hFF);
        pulse_ce(1);
        rd("R3", 2'd0, 8'hFF);
        chk("R3", "tf0 early", {7'b0, tf0}, 8'h0);
        pulse_ce(1);
        rd("R3", 2'd0, 8'hE0); rd("R3", 2'd1, 8'h00);
        chk("R3", "tf0 wrap", {7'b0, tf0}, 8'h1);
    endtask

    task automatic t_reload();
        do_reset();
        t0_mode = 2'd2; run = 2'b01;
        wr(2'd1, 8'h40); wr(2'd0, 8'hFF);
        pulse_ce(1);
        rd("R4", 2'd0, 8'h40); rd("R4", 2'd1, 8'h40);
        chk("R4", "tf0", {7'b0, tf0}, 8'h1);
        pulse_ce(3);
        rd("R4", 2'd0, 8'h43);
    endtask

    task automatic t_prescale();
        do_reset();
        t0_mode = 2'd1; run = 2'b01; div12_sel = 2'b01;
        pulse_ce(11);
        rd("R5", 2'd0, 8'h00);
        pulse_ce(1);
        rd("R5", 2'd0, 8'h01);
        pulse_ce(12);
        rd("R5", 2'd0, 8'h02);
        div12_sel = 2'b00;
        repeat (5) @(negedge clk);
        rd("R5", 2'd0, 8'h02);
        pulse_ce(3);
        rd("R5", 2'd0, 8'h05);
    endtask

    task automatic t_counter();
        do_reset();
        t0_mode = 2'd1; run = 2'b01; ext_sel = 2'b01;
        pulse_ce(5);
        rd("R6", 2'd0, 8'h00);
        for (int k = 0; k < 3; k++) begin
            cnt_pin[0] = 1'b1;
            repeat (4) @(negedge clk);
            cnt_pin[0] = 1'b0;
            repeat (4) @(negedge clk);
        end
        rd("R6", 2'd0, 8'h03);
    endtask

    task automatic t_gate();
        do_reset();
        t0_mode = 2'd1; run = 2'b01; gate_en = 2'b01; gate_pin = 2'b00;
        pulse_ce(4);
        rd("R7", 2'd0, 8'h00);
        gate_pin = 2'b01;
        pulse_ce(4);
        rd("R7", 2'd0, 8'h04);
        run = 2'b00;
        pulse_ce(3);
        rd("R7", 2'd0, 8'h04);
    endtask

    task automatic t_split();
        do_reset();
        t0_mode = 2'd3; t1_mode = 2'd1; run = 2'b01;
        wr(2'd0, 8'hFE); wr(2'd1, 8'hFE);
        pulse_ce(2);
        rd("R8", 2'd0, 8'h00); rd("R8", 2'd1, 8'hFE);
        chk("R8", "tf0", {7'b0, tf0}, 8'h1);
        chk("R8", "tf1", {7'b0, tf1}, 8'h0);
        run = 2'b10; ext_sel = 2'b01; gate_en = 2'b01;
        pulse_ce(2);
        rd("R9", 2'd0, 8'h00); rd("R9", 2'd1, 8'h00);
        chk("R9", "tf1", {7'b0, tf1}, 8'h1);
        rd("R10", 2'd2, 8'h04);
    endtask

    task automatic t_t1_split_wrap();
        do_reset();
        t0_mode = 2'd3; t1_mode = 2'd1; run = 2'b00;
        gate_en = 2'b10; ext_sel = 2'b10;
        wr(2'd2, 8'hFF); wr(2'd3, 8'hFF);
        pulse_ce(1);
        rd("R10", 2'd2, 8'h00); rd("R10", 2'd3, 8'h00);
        chk("R12", "pulse", {7'b0, t1_ovf_pulse}, 8'h1);
        chk("R10", "tf1", {7'b0, tf1}, 8'h0);
        @(negedge clk);
        chk("R12", "pulse width", {7'b0, t1_ovf_pulse}, 8'h0);
    endtask

    task automatic t_t1_stop();
        do_reset();
        t1_mode = 2'd3; run = 2'b10;
        wr(2'd2, 8'h55);
        pulse_ce(5);
        rd("R11", 2'd2, 8'h55);
        t1_mode = 2'd1;
        pulse_ce(2);
        rd("R11", 2'd2, 8'h57);
    endtask

    task automatic t_t1_normal();
        do_reset();
        t1_mode = 2'd1; run = 2'b10;
        wr(2'd2, 8'hFF); wr(2'd3, 8'hFF);
        pulse_ce(1);
        chk("R12", "tf1", {7'b0, tf1}, 8'h1);
        chk("R12", "pulse", {7'b0, t1_ovf_pulse}, 8'h1);
        rd("R12", 2'd3, 8'h00);
    endtask

    task automatic t_flag_race();
        do_reset();
        t0_mode = 2'd1; run = 2'b01;
        wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
        @(negedge clk);
        ce = 1'b1; flag_wr = 2'b01; flag_wdata = 2'b00;
        @(negedge clk);
        ce = 1'b0; flag_wr = 2'b00;
        chk("R13", "set beats clear", {7'b0, tf0}, 8'h1);
        @(negedge clk);
        chk("R13", "held", {7'b0, tf0}, 8'h1);
        clr_flags();
        chk("R13", "cleared", {7'b0, tf0}, 8'h0);
    endtask

    task automatic t_write();
        do_reset();
        t0_mode = 2'd1; run = 2'b01;
        pulse_ce(2);
        @(negedge clk);
        ce = 1'b1; wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h10;
        @(negedge clk);
        ce = 1'b0; wr_en = 1'b0;
        rd("R14", 2'd0, 8'h10);
        wr(2'd3, 8'hA5);
        rd("R14", 2'd3, 8'hA5);
        rd("R14", 2'd1, 8'h00);
    endtask

    initial begin
        t_reset();
        t_mode16();
        t_mode13();
        t_reload();
        t_prescale();
        t_counter();
        t_gate();
        t_split();
        t_t1_split_wrap();
        t_t1_stop();
        t_t1_normal();
        t_flag_race();
        t_write();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule